// File: doc/BRIEF.md
# I2C Register Slave with Dual Address and Burst Pointer

This block is an I2C target that gives a host access to a small register file through an internal byte pointer that advances on its own. It answers to two 7-bit device addresses supplied from outside the block. Each address selects its own register bank, so one physical device looks like two devices on the bus. The first data byte of a write loads the pointer. Every later byte is written at the pointer, which then steps forward. A read returns the byte at the pointer and advances it, for as long as the host keeps acknowledging.

SCL and SDA are brought into the system clock domain through multi-flop synchronizers. START and STOP are recognised from SDA edges while SCL is high. The block drives SDA only as an open-drain output enable, and only for acknowledge bits and for the zero bits of read data. The register file itself sits outside the block and is reached through a simple strobe port. Pointer values outside a configurable window of implemented registers are never written, and they read back as zero.

Top module: `i2c_dual_bank_regslv`

## Requirements
- R1: A falling SDA while SCL is high (START) begins a new address phase from any state, so a repeated START works in place of a STOP. A rising SDA while SCL is high (STOP) returns the block to idle. Bytes clocked outside a transaction get no acknowledge and cause no register access.
- R2: Bits are taken on the rising edge of SCL, most significant bit first. The block changes its SDA drive only while SCL is low.
- R3: In the first byte after START, bits 7:1 hold the device address and bit 0 the direction (0 write, 1 read). A match with `base_lo` selects bank 0, and a match with `base_hi` selects bank 1; `base_lo` wins if the two are equal. A matching byte is acknowledged by pulling SDA low during the ninth clock. Any other byte gets no acknowledge and is ignored until the next START.
- R4: In a write, the first data byte loads the pointer. Each later byte is written at the pointer, after which the pointer increments. Every data byte is acknowledged, and bursts have no length limit.
- R5: In a read, the block sends the byte at the pointer and increments the pointer. It carries on while the host drives SDA low in the ninth clock. After a host NACK it releases SDA and stays silent until the next START.
- R6: The pointer is `PTR_W` bits wide and wraps from its maximum to zero. It keeps its value across transactions, so a write that only sets the pointer can be followed by a read from that location.
- R7: Only pointer values from `REG_FIRST` to `REG_LAST` are implemented. Writes outside that window are acknowledged but produce no `reg_wr_en`. Reads outside it return 00h without `reg_rd_en`. The pointer advances in both cases, and each byte of a burst is checked on its own.
- R8: After reset, and at every moment other than an acknowledge bit or a zero read-data bit, `sda_oe` is 0 (SDA released).
- R9: A register write is a one-cycle `reg_wr_en` pulse with `reg_addr` equal to the pointer, together with `reg_bank` and `reg_wdata`. A register read is a one-cycle `reg_rd_en` pulse, and `reg_rdata` is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| base_lo | input | 7 | Device address that selects bank 0 |
| base_hi | input | 7 | Device address that selects bank 1 |
| reg_wr_en | output | 1 | Register write strobe |
| reg_rd_en | output | 1 | Register read strobe |
| reg_bank | output | 1 | Bank of the current access |
| reg_addr | output | PTR_W | Register index (current pointer) |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, combinational from the register file |

## Verification
The bench builds the block with its defaults: an 8-bit pointer, implemented registers 1 to 5, and two synchronizer stages. Because the pointer is only 8 bits wide, loading FFh and reading three bytes is enough to reach the wrap to zero. The narrow implemented window puts unimplemented indices on both sides of the real registers, including index 0, so writes and reads that cross either edge are easy to produce. The bench's register model holds non-zero values at the unimplemented indices, which exposes any leak of their contents onto SDA.

// File: rtl/i2c_regslv_pkg.sv
package i2c_regslv_pkg;

   localparam int unsigned DEV_AW = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR_BYTE,
      ST_WR_ACK,
      ST_RD_BYTE,
      ST_RD_ACK
   } slv_state_t;

   typedef struct packed {
      logic scl_lvl;
      logic sda_lvl;
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } bus_ev_t;

endpackage

// File: rtl/i2c_regslv_sync.sv
module i2c_regslv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_regslv_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], line_i};
         prev  <= chain[STAGES-1];
      end
   end

   assign lvl_o  = chain[STAGES-1];
   assign rise_o = chain[STAGES-1] & ~prev;
   assign fall_o = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/i2c_regslv_cond.sv
module i2c_regslv_cond
   import i2c_regslv_pkg::*;
(
   input  logic    scl_lvl,
   input  logic    scl_rise,
   input  logic    scl_fall,
   input  logic    sda_lvl,
   input  logic    sda_rise,
   input  logic    sda_fall,
   output bus_ev_t ev_o
);

   always_comb begin
      ev_o.scl_lvl  = scl_lvl;
      ev_o.sda_lvl  = sda_lvl;
      ev_o.scl_rise = scl_rise;
      ev_o.scl_fall = scl_fall;
      ev_o.start    = sda_fall & scl_lvl & ~scl_rise;
      ev_o.stop     = sda_rise & scl_lvl & ~scl_rise;
   end

endmodule

// File: rtl/i2c_regslv_gate.sv
module i2c_regslv_gate #(
   parameter int PTR_W     = 8,
   parameter int REG_FIRST = 1,
   parameter int REG_LAST  = 5
) (
   input  logic [PTR_W-1:0] ptr_i,
   input  logic [7:0]       rdata_i,
   output logic             impl_o,
   output logic [7:0]       byte_o
);

   localparam int               PTR_MAX = (1 << PTR_W) - 1;
   localparam logic [PTR_W-1:0] LO_P    = PTR_W'(REG_FIRST);
   localparam logic [PTR_W-1:0] HI_P    = PTR_W'(REG_LAST);

   if (REG_FIRST == 0 && REG_LAST == PTR_MAX) begin : g_full
      assign impl_o = 1'b1;
   end else if (REG_FIRST == 0) begin : g_upper
      assign impl_o = (ptr_i <= HI_P);
   end else if (REG_LAST == PTR_MAX) begin : g_lower
      assign impl_o = (ptr_i >= LO_P);
   end else begin : g_window
      assign impl_o = (ptr_i >= LO_P) && (ptr_i <= HI_P);
   end

   assign byte_o = impl_o ? rdata_i : 8'h00;

endmodule

// File: rtl/i2c_regslv_fsm.sv
module i2c_regslv_fsm
   import i2c_regslv_pkg::*;
#(
   parameter int PTR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_ev_t           ev,
   input  logic [DEV_AW-1:0] base_lo,
   input  logic [DEV_AW-1:0] base_hi,
   input  logic              impl_i,
   input  logic [7:0]        fetch_byte_i,
   output logic              sda_oe_o,
   output logic              wr_stb_o,
   output logic              rd_stb_o,
   output logic [7:0]        wdata_o,
   output logic              bank_o,
   output logic [PTR_W-1:0]  ptr_o
);

   localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

   slv_state_t       state;
   logic [2:0]       bitcnt;
   logic [7:0]       sh;
   logic [7:0]       tx;
   logic [PTR_W-1:0] ptr;
   logic             bank;
   logic             need_ptr;
   logic             is_rd;
   logic             matched;
   logic             byte_full;
   logic             oe;

   logic       live;
   logic [7:0] full_byte;
   logic       hit_lo;
   logic       hit_hi;
   logic       fetch;

   assign live      = ~ev.start & ~ev.stop;
   assign full_byte = {sh[6:0], ev.sda_lvl};
   assign hit_lo    = (full_byte[7:1] == base_lo);
   assign hit_hi    = (full_byte[7:1] == base_hi);

   assign fetch = live & ev.scl_rise &
                  (((state == ST_ADDR_ACK) & is_rd) |
                   ((state == ST_RD_ACK) & ~ev.sda_lvl));

   assign wr_stb_o = live & ev.scl_rise & (state == ST_WR_BYTE) &
                     (bitcnt == 3'd7) & ~need_ptr & impl_i;
   assign rd_stb_o = fetch & impl_i;
   assign wdata_o  = full_byte;
   assign sda_oe_o = oe;
   assign bank_o   = bank;
   assign ptr_o    = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         sh        <= '0;
         tx        <= '0;
         ptr       <= '0;
         bank      <= 1'b0;
         need_ptr  <= 1'b1;
         is_rd     <= 1'b0;
         matched   <= 1'b0;
         byte_full <= 1'b0;
         oe        <= 1'b0;
      end else if (ev.start) begin
         state     <= ST_ADDR;
         bitcnt    <= '0;
         byte_full <= 1'b0;
         need_ptr  <= 1'b1;
         oe        <= 1'b0;
      end else if (ev.stop) begin
         state     <= ST_IDLE;
         byte_full <= 1'b0;
         oe        <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR: begin
               if (ev.scl_rise) begin
                  sh     <= full_byte;
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) begin
                     byte_full <= 1'b1;
                     matched   <= hit_lo | hit_hi;
                     bank      <= ~hit_lo;
                     is_rd     <= full_byte[0];
                  end
               end else if (ev.scl_fall && byte_full) begin
                  byte_full <= 1'b0;
                  if (matched) begin
                     oe    <= 1'b1;
                     state <= ST_ADDR_ACK;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (ev.scl_rise && is_rd) begin
                  tx  <= fetch_byte_i;
                  ptr <= ptr + PTR_ONE;
               end else if (ev.scl_fall) begin
                  bitcnt <= '0;
                  if (is_rd) begin
                     oe    <= ~tx[7];
                     tx    <= {tx[6:0], 1'b0};
                     state <= ST_RD_BYTE;
                  end else begin
                     oe    <= 1'b0;
                     state <= ST_WR_BYTE;
                  end
               end
            end
            ST_WR_BYTE: begin
               if (ev.scl_rise) begin
                  sh     <= full_byte;
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) begin
                     byte_full <= 1'b1;
                     if (need_ptr) begin
                        ptr      <= PTR_W'(full_byte);
                        need_ptr <= 1'b0;
                     end else begin
                        ptr <= ptr + PTR_ONE;
                     end
                  end
               end else if (ev.scl_fall && byte_full) begin
                  byte_full <= 1'b0;
                  oe        <= 1'b1;
                  state     <= ST_WR_ACK;
               end
            end
            ST_WR_ACK: begin
               if (ev.scl_fall) begin
                  oe     <= 1'b0;
                  bitcnt <= '0;
                  state  <= ST_WR_BYTE;
               end
            end
            ST_RD_BYTE: begin
               if (ev.scl_fall) begin
                  if (bitcnt == 3'd7) begin
                     oe    <= 1'b0;
                     state <= ST_RD_ACK;
                  end else begin
                     oe     <= ~tx[7];
                     tx     <= {tx[6:0], 1'b0};
                     bitcnt <= bitcnt + 3'd1;
                  end
               end
            end
            ST_RD_ACK: begin
               if (ev.scl_rise) begin
                  if (ev.sda_lvl) begin
                     state <= ST_IDLE;
                  end else begin
                     tx  <= fetch_byte_i;
                     ptr <= ptr + PTR_ONE;
                  end
               end else if (ev.scl_fall) begin
                  oe     <= ~tx[7];
                  tx     <= {tx[6:0], 1'b0};
                  bitcnt <= '0;
                  state  <= ST_RD_BYTE;
               end
            end
            default: begin
               oe <= 1'b0;
            end
         endcase
      end
   end

   AST_OE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> (state inside {ST_ADDR_ACK, ST_WR_ACK, ST_RD_BYTE})); // R8

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (oe != $past(oe)) |-> !ev.scl_lvl); // R2

   AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.stop && !ev.start) |=> (state == ST_IDLE) && !oe); // R1

   AST_WR_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |=> (ptr == $past(ptr) + PTR_ONE)); // R4

   AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (live && state == ST_RD_ACK && ev.scl_rise && ev.sda_lvl) |=> !oe); // R5

endmodule

// File: rtl/i2c_dual_bank_regslv.sv
module i2c_dual_bank_regslv
   import i2c_regslv_pkg::*;
#(
   parameter int PTR_W       = 8,
   parameter int REG_FIRST   = 1,
   parameter int REG_LAST    = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe,
   input  logic [6:0]       base_lo,
   input  logic [6:0]       base_hi,
   output logic             reg_wr_en,
   output logic             reg_rd_en,
   output logic             reg_bank,
   output logic [PTR_W-1:0] reg_addr,
   output logic [7:0]       reg_wdata,
   input  logic [7:0]       reg_rdata
);

   if (PTR_W < 1 || PTR_W > 16) begin : g_bad_ptr
      $error("i2c_dual_bank_regslv: PTR_W out of range");
   end
   if (REG_FIRST < 0 || REG_FIRST > REG_LAST || REG_LAST > (1 << PTR_W) - 1) begin : g_bad_win
      $error("i2c_dual_bank_regslv: implemented window does not fit the pointer");
   end

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;
   bus_ev_t ev;
   logic       impl;
   logic [7:0] fetch_byte;
   logic [PTR_W-1:0] ptr;

   i2c_regslv_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i),
      .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
   );

   i2c_regslv_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i),
      .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
   );

   i2c_regslv_cond u_cond (
      .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
      .ev_o(ev)
   );

   i2c_regslv_gate #(.PTR_W(PTR_W), .REG_FIRST(REG_FIRST), .REG_LAST(REG_LAST)) u_gate (
      .ptr_i(ptr), .rdata_i(reg_rdata), .impl_o(impl), .byte_o(fetch_byte)
   );

   i2c_regslv_fsm #(.PTR_W(PTR_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .ev(ev),
      .base_lo(base_lo), .base_hi(base_hi),
      .impl_i(impl), .fetch_byte_i(fetch_byte),
      .sda_oe_o(sda_oe), .wr_stb_o(reg_wr_en), .rd_stb_o(reg_rd_en),
      .wdata_o(reg_wdata), .bank_o(reg_bank), .ptr_o(ptr)
   );

   assign reg_addr = ptr;

   AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> (int'(reg_addr) >= REG_FIRST) && (int'(reg_addr) <= REG_LAST)); // R7

   AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en |-> (int'(reg_addr) >= REG_FIRST) && (int'(reg_addr) <= REG_LAST)); // R7

   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en || reg_rd_en) |=> !(reg_wr_en || reg_rd_en)); // R9

endmodule

// File: tb/i2c_dual_bank_regslv_tb_top.sv
module i2c_dual_bank_regslv_tb_top;

   localparam int         Q        = 8;
   localparam logic [6:0] ADR_LO   = 7'h21;
   localparam logic [6:0] ADR_HI   = 7'h22;
   localparam logic [6:0] ADR_NONE = 7'h30;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_low = 1'b0;
   logic sda_bus;
   logic sda_oe;
   logic reg_wr_en, reg_rd_en, reg_bank;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic [7:0] rf [0:1][0:7];

   int n_chk  = 0;
   int n_bad  = 0;
   int wr_cnt = 0;
   bit finished = 1'b0;

   int         exp_req[$];
   logic [7:0] exp_val[$];
   logic [7:0] act_val[$];

   always #10 clk = ~clk;

   assign sda_bus   = ~(m_low | sda_oe);
   assign reg_rdata = (reg_addr < 8'd8) ? rf[reg_bank][reg_addr[2:0]] : 8'hA5;

   i2c_dual_bank_regslv dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
      .base_lo(ADR_LO), .base_hi(ADR_HI),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_bank(reg_bank),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
      end
   endtask

   // register file model; R7 and R9: strobes only inside the window
   always @(posedge clk) begin
      if (reg_wr_en) begin
         wr_cnt++;
         if (reg_addr >= 8'd1 && reg_addr <= 8'd5)
            rf[reg_bank][reg_addr[2:0]] <= reg_wdata;
         else
            chk(7, reg_addr, 8'h01);
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      while (act_val.size() > 0 && exp_val.size() > 0)
         chk(exp_req.pop_front(), act_val.pop_front(), exp_val.pop_front());
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_out(input logic b);
      m_low = ~b; tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bit_in(output logic b);
      m_low = 1'b0; tick(Q);
      m_scl = 1'b1; tick(Q);
      b = sda_bus; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic i2c_start();
      m_low = 1'b0; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_low = 1'b1; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic i2c_stop();
      m_low = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_low = 1'b0; tick(Q);
   endtask

   task automatic expect_push(input int req, input logic [7:0] v);
      exp_req.push_back(req);
      exp_val.push_back(v);
   endtask

   // exp_nak: 0 means the slave must acknowledge
   task automatic wr_byte(input int req, input logic [7:0] b, input logic exp_nak);
      logic a;
      expect_push(req, {7'b0, exp_nak});
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      bit_in(a);
      act_val.push_back({7'b0, a});
   endtask

   task automatic rd_byte(input int req, input logic [7:0] exp, input logic host_ack);
      logic [7:0] d;
      logic       x;
      expect_push(req, exp);
      for (int i = 7; i >= 0; i--) begin
         bit_in(x);
         d[i] = x;
      end
      bit_out(~host_ack);
      act_val.push_back(d);
   endtask

   initial begin
      int w0;
      logic x;
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < 8; i++)
            rf[b][i] = 8'h40 + 8'(b * 16 + i);
      tick(5);
      rst_n = 1'b1;
      tick(4);
      // R8: released after reset, R9: no strobes
      chk(8, {7'b0, sda_oe}, 8'h00);
      chk(9, {6'b0, reg_wr_en, reg_rd_en}, 8'h00);

      // R3 R4: burst write to bank 0 registers 1..5
      i2c_start();
      wr_byte(3, {ADR_LO, 1'b0}, 1'b0);
      wr_byte(4, 8'h01, 1'b0);
      wr_byte(4, 8'hA1, 1'b0);
      wr_byte(4, 8'hB2, 1'b0);
      wr_byte(4, 8'hC3, 1'b0);
      wr_byte(4, 8'hD4, 1'b0);
      wr_byte(4, 8'hE5, 1'b0);
      i2c_stop();
      tick(4*Q);

      // R1 repeated START, R2 MSB first, R5 burst read, R9 read data path
      i2c_start();
      wr_byte(3, {ADR_LO, 1'b0}, 1'b0);
      wr_byte(4, 8'h01, 1'b0);
      i2c_start();
      wr_byte(3, {ADR_LO, 1'b1}, 1'b0);
      rd_byte(2, 8'hA1, 1'b1);
      rd_byte(5, 8'hB2, 1'b1);
      rd_byte(5, 8'hC3, 1'b1);
      rd_byte(5, 8'hD4, 1'b1);
      rd_byte(9, 8'hE5, 1'b0);
      i2c_stop();
      tick(4*Q);

      // R3: foreign address gets no ACK, following byte ignored
      w0 = wr_cnt;
      i2c_start();
      wr_byte(3, {ADR_NONE, 1'b0}, 1'b1);
      wr_byte(3, 8'h02, 1'b1);
      i2c_stop();
      tick(4*Q);
      chk(3, 8'(wr_cnt - w0), 8'h00);

      // R3: upper address selects bank 1
      i2c_start();
      wr_byte(3, {ADR_HI, 1'b0}, 1'b0);
      wr_byte(4, 8'h03, 1'b0);
      wr_byte(4, 8'h5A, 1'b0);
      i2c_stop();
      i2c_start();
      wr_byte(3, {ADR_HI, 1'b0}, 1'b0);
      wr_byte(4, 8'h03, 1'b0);
      i2c_start();
      wr_byte(3, {ADR_HI, 1'b1}, 1'b0);
      rd_byte(3, 8'h5A, 1'b0);
      i2c_stop();
      i2c_start();
      wr_byte(3, {ADR_LO, 1'b0}, 1'b0);
      wr_byte(4, 8'h03, 1'b0);
      i2c_start();
      wr_byte(3, {ADR_LO, 1'b1}, 1'b0);
      rd_byte(3, 8'hC3, 1'b0);
      i2c_stop();
      tick(4*Q);

      // R7: burst crossing the top of the window
      w0 = wr_cnt;
      i2c_start();
      wr_byte(3, {ADR_LO, 1'b0}, 1'b0);
      wr_byte(4, 8'h04, 1'b0);
      wr_byte(7, 8'h11, 1'b0);
      wr_byte(7, 8'h22, 1'b0);
      wr_byte(7, 8'h33, 1'b0);
      i2c_stop();
      tick(4*Q);
      chk(7, 8'(wr_cnt - w0), 8'h02);
      i2c_start();
      wr_byte(3, {ADR_LO, 1'b0}, 1'b0);
      wr_byte(4, 8'h04, 1'b0);
      i2c_start();
      wr_byte(3, {ADR_LO, 1'b1}, 1'b0);
      rd_byte(7, 8'h11, 1'b1);
      rd_byte(7, 8'h22, 1'b1);
      rd_byte(7, 8'h00, 1'b1);
      rd_byte(7, 8'h00, 1'b0);
      i2c_stop();
      tick(4*Q);

      // R6: pointer wraps FFh -> 00h, index 0 is unimplemented (R7)
      i2c_start();
      wr_byte(3, {ADR_LO, 1'b0}, 1'b0);
      wr_byte(4, 8'hFF, 1'b0);
      i2c_start();
      wr_byte(3, {ADR_LO, 1'b1}, 1'b0);
      rd_byte(6, 8'h00, 1'b1);
      rd_byte(6, 8'h00, 1'b1);
      rd_byte(6, 8'hA1, 1'b0);
      i2c_stop();
      tick(4*Q);

      // R6: pointer persists; R5: silent after NACK
      i2c_start();
      wr_byte(3, {ADR_LO, 1'b1}, 1'b0);
      rd_byte(6, 8'hB2, 1'b0);
      bit_in(x);
      chk(5, {7'b0, x}, 8'h01);
      i2c_stop();
      tick(4*Q);

      // R1: STOP ends the transaction, later clocks are ignored
      w0 = wr_cnt;
      i2c_start();
      wr_byte(3, {ADR_LO, 1'b0}, 1'b0);
      wr_byte(4, 8'h01, 1'b0);
      i2c_stop();
      tick(2*Q);
      m_scl = 1'b0;
      tick(Q);
      for (int i = 7; i >= 0; i--) bit_out(1'(8'h77 >> i));
      bit_in(x);
      chk(1, {7'b0, x}, 8'h01);
      i2c_stop();
      tick(4*Q);
      chk(1, 8'(wr_cnt - w0), 8'h00);
      chk(8, {7'b0, sda_oe}, 8'h00);

      tick(20);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule